// File: doc/BRIEF.md
# Interrupt controller command decoder

This block is the byte-wide programming front end of an eight-input interrupt controller. Software reaches it through two addresses. Address 0 carries two kinds of byte. One starts the setup sequence. The other is a run-time command: end-of-interrupt, or a choice of which status register reads back. Address 1 carries the mask, or the next setup byte while the setup sequence is running. The block does not arbitrate interrupts and takes no part in the acknowledge cycle.

A short sequencer steps through up to four setup bytes. It skips the cascade byte in single mode. It skips the final mode byte when the opening byte did not ask for one. The block holds these settings and drives them to the interrupt core: trigger style, single/cascade mode, vector base, cascade map or slave identity, and automatic end-of-interrupt. It also sends the core a one-cycle end-of-interrupt strobe with a line number. Rotation commands and special-mask commands are accepted and have no effect.

Top module: `pic_cmd_decoder`

## Requirements
- R1: A write to address 0 with bit 4 set opens setup in the cycle after the write. It clears the mask to 0x00, sets `edge_mode` from bit 3 and `single_mode` from bit 1, and arms the vector step. The next write to address 1 is then the vector byte.
- R2: An opening byte with bit 0 clear forces `auto_eoi` to 0. An opening byte with bit 0 set leaves `auto_eoi` unchanged.
- R3: The vector byte sets `vec_base` to the byte with bits 2:0 cleared. In single mode it also clears `cascade_map` and ends setup, even when a mode byte was requested. In cascade mode it moves to the cascade step.
- R4: A master (IS_MASTER=1) stores the cascade byte whole in `cascade_map`. A slave (IS_MASTER=0) stores only bits 2:0 and zeroes the rest. Setup then moves to the mode step if one was requested, and ends otherwise.
- R5: In the mode step, `auto_eoi` takes bit 1 of the byte and the other bits are ignored. Setup then ends.
- R6: Outside setup, a write to address 1 loads the mask. During setup, only an opening byte changes the mask. A read of address 1 returns the mask.
- R7: A write to address 0 with bits 4:3 = 00 is an end-of-interrupt command, coded in bits 7:5. Code 3 raises `eoi_valid` for exactly the one cycle after the write, with `eoi_line` equal to bits 2:0.
- R8: Code 1 raises the strobe with `eoi_line` equal to the index of the highest set bit of `isr_in`, taken in the write cycle. If `isr_in` is 0x00, there is no strobe.
- R9: Codes 0, 2, 4, 5, 6 and 7 (the rotation, priority and no-op codes) raise no strobe and leave the mask and the read selection unchanged.
- R10: A write to address 0 with bits 4:3 = 01 and bit 1 set makes `rd_sel_irr` equal to bit 0. With bit 1 clear, the selection is unchanged. A read of address 0 returns `irr_in` when `rd_sel_irr` is 1 and `isr_in` when it is 0.
- R11: After reset, every setting and the mask are 0, `rd_sel_irr` is 1, there is no strobe, and setup is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 1 | Register address for writes and reads |
| wdata | input | 8 | Write byte |
| irr_in | input | 8 | Request register from the interrupt core |
| isr_in | input | 8 | In-service register from the interrupt core |
| rd_data | output | 8 | Combinational read data for `addr` |
| mask_q | output | 8 | Interrupt mask |
| edge_mode | output | 1 | 1 = edge-triggered inputs |
| single_mode | output | 1 | 1 = single controller, 0 = cascaded |
| vec_base | output | 8 | Vector base, low three bits zero |
| cascade_map | output | 8 | Master: inputs with slaves; slave: own identity |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| rd_sel_irr | output | 1 | Address 0 reads the request register |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_line | output | 3 | Line cleared by the strobe |

## Verification
The bench builds two copies side by side and feeds them the same writes. One is the default master (IS_MASTER=1) and the other a slave (IS_MASTER=0), so the single difference in cascade-byte storage is compared directly. Because the port is eight bits wide, the bench sweeps every mask value, every vector byte and every in-service pattern for the highest-line search. It also tries all sixteen opening-byte combinations with both values of the automatic end-of-interrupt bit, and every command code against every line field.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int LINE_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VEC  = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_INIT  = 2'd0,
    CMD_EOI   = 2'd1,
    CMD_RDSEL = 2'd2
  } cmd_kind_e;

  localparam logic [2:0] EOI_NONSPEC = 3'd1;
  localparam logic [2:0] EOI_SPEC    = 3'd3;

  // Class of a byte written to address 0.
  function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
    if (b[4])      return CMD_INIT;
    else if (!b[3]) return CMD_EOI;
    else           return CMD_RDSEL;
  endfunction

  // {found, index} of the highest set bit.
  function automatic logic [LINE_W:0] top_bit(input logic [BYTE_W-1:0] v);
    logic [LINE_W:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (v[i]) r = {1'b1, LINE_W'(i)};
    end
    return r;
  endfunction

  // Vector base keeps only the bits above the line index.
  function automatic logic [BYTE_W-1:0] base_of(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-1:LINE_W], {LINE_W{1'b0}}};
  endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              seq_idle,
  output logic              mask_clear,
  output logic              edge_mode,
  output logic              single_mode,
  output logic [BYTE_W-1:0] vec_base,
  output logic [BYTE_W-1:0] cascade_map,
  output logic              auto_eoi
);

  seq_state_e        state_q;
  logic              want_mode_q;
  logic [BYTE_W-1:0] casc_next;
  logic              cfg_wr;

  assign mask_clear = wr_en && !addr && (classify(wdata) == CMD_INIT);
  assign cfg_wr     = wr_en && addr;
  assign seq_idle   = (state_q == SEQ_IDLE);

  generate
    if (IS_MASTER) begin : g_master
      assign casc_next = wdata;
    end else begin : g_slave
      assign casc_next = {{(BYTE_W-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      want_mode_q <= 1'b0;
      edge_mode   <= 1'b0;
      single_mode <= 1'b0;
      vec_base    <= '0;
      cascade_map <= '0;
      auto_eoi    <= 1'b0;
    end else if (mask_clear) begin
      edge_mode   <= wdata[3];
      single_mode <= wdata[1];
      want_mode_q <= wdata[0];
      if (!wdata[0]) auto_eoi <= 1'b0;
      state_q     <= SEQ_VEC;
    end else if (cfg_wr) begin
      unique case (state_q)
        SEQ_VEC: begin
          vec_base <= base_of(wdata);
          if (single_mode) begin
            cascade_map <= '0;
            state_q     <= SEQ_IDLE;
          end else begin
            state_q <= SEQ_CASC;
          end
        end
        SEQ_CASC: begin
          cascade_map <= casc_next;
          state_q     <= want_mode_q ? SEQ_MODE : SEQ_IDLE;
        end
        SEQ_MODE: begin
          auto_eoi <= wdata[1];
          state_q  <= SEQ_IDLE;
        end
        default: ;
      endcase
    end
  end

  AST_SINGLE_NO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |-> (state_q != SEQ_CASC)); // R3
  AST_MODE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_MODE) |-> want_mode_q); // R5
  AST_NO_MODE_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clear && !wdata[0]) |=> !auto_eoi); // R2
  AST_OPEN_ARMS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clear |=> (state_q == SEQ_VEC)); // R1

endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
  import pic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              seq_idle,
  input  logic              mask_clear,
  input  logic [BYTE_W-1:0] isr_in,
  output logic [BYTE_W-1:0] mask_q,
  output logic              rd_sel_irr,
  output logic              eoi_valid,
  output logic [LINE_W-1:0] eoi_line
);

  cmd_kind_e       kind;
  logic [2:0]      code;
  logic [LINE_W:0] isr_top;
  logic            cmd_wr;
  logic            eoi_fire;
  logic [LINE_W-1:0] eoi_pick;

  assign kind    = classify(wdata);
  assign code    = wdata[7:5];
  assign isr_top = top_bit(isr_in);
  assign cmd_wr  = wr_en && !addr;

  always_comb begin
    eoi_fire = 1'b0;
    eoi_pick = wdata[LINE_W-1:0];
    if (cmd_wr && kind == CMD_EOI) begin
      if (code == EOI_SPEC) begin
        eoi_fire = 1'b1;
      end else if (code == EOI_NONSPEC) begin
        eoi_fire = isr_top[LINE_W];
        eoi_pick = isr_top[LINE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      rd_sel_irr <= 1'b1;
      eoi_valid  <= 1'b0;
      eoi_line   <= '0;
    end else begin
      if (mask_clear)
        mask_q <= '0;
      else if (wr_en && addr && seq_idle)
        mask_q <= wdata;
      if (cmd_wr && kind == CMD_RDSEL && wdata[1])
        rd_sel_irr <= wdata[0];
      eoi_valid <= eoi_fire;
      if (eoi_fire) eoi_line <= eoi_pick;
    end
  end

  AST_OPEN_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clear |=> (mask_q == '0)); // R1
  AST_MASK_HELD_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && !mask_clear) |=> $stable(mask_q)); // R6
  AST_EOI_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoi_valid) |-> $past(wr_en && !addr)); // R7
  AST_NONSPEC_NEEDS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && $past(wdata[7:5] == EOI_NONSPEC && !wdata[4] && !wdata[3]))
      |-> ($past(isr_in) != '0)); // R8
  AST_RDSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wdata[4] && wdata[3] && !wdata[1]) |=> $stable(rd_sel_irr)); // R10

endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic [7:0] irr_in,
  input  logic [7:0] isr_in,
  output logic [7:0] rd_data,
  output logic [7:0] mask_q,
  output logic       edge_mode,
  output logic       single_mode,
  output logic [7:0] vec_base,
  output logic [7:0] cascade_map,
  output logic       auto_eoi,
  output logic       rd_sel_irr,
  output logic       eoi_valid,
  output logic [2:0] eoi_line
);

  // Events between the two halves, named for the assertions.
  logic seq_idle;
  logic mask_clear;

  pic_init_seq #(.IS_MASTER(IS_MASTER)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .seq_idle    (seq_idle),
    .mask_clear  (mask_clear),
    .edge_mode   (edge_mode),
    .single_mode (single_mode),
    .vec_base    (vec_base),
    .cascade_map (cascade_map),
    .auto_eoi    (auto_eoi)
  );

  pic_ocw_decode u_ocw (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .seq_idle   (seq_idle),
    .mask_clear (mask_clear),
    .isr_in     (isr_in),
    .mask_q     (mask_q),
    .rd_sel_irr (rd_sel_irr),
    .eoi_valid  (eoi_valid),
    .eoi_line   (eoi_line)
  );

  always_comb begin
    if (addr)            rd_data = mask_q;
    else if (rd_sel_irr) rd_data = irr_in;
    else                 rd_data = isr_in;
  end

  AST_SETUP_VEC_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_idle) |-> $past(mask_clear)); // R1

endmodule

// File: tb/test_pic_cmd_decoder.sv
`timescale 1ns/1ps
module test_pic_cmd_decoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] irr_in = 8'hC3;
  logic [7:0] isr_in = 8'h18;

  logic [7:0] rd_data, mask_q, vec_base, cascade_map;
  logic       edge_mode, single_mode, auto_eoi, rd_sel_irr, eoi_valid;
  logic [2:0] eoi_line;
  logic [7:0] s_rd_data, s_mask_q, s_vec_base, s_cascade_map;
  logic       s_edge_mode, s_single_mode, s_auto_eoi, s_rd_sel_irr, s_eoi_valid;
  logic [2:0] s_eoi_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic_cmd_decoder #(.IS_MASTER(1'b1)) i_pic_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irr_in(irr_in), .isr_in(isr_in), .rd_data(rd_data), .mask_q(mask_q),
    .edge_mode(edge_mode), .single_mode(single_mode), .vec_base(vec_base),
    .cascade_map(cascade_map), .auto_eoi(auto_eoi), .rd_sel_irr(rd_sel_irr),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line));

  pic_cmd_decoder #(.IS_MASTER(1'b0)) i_pic_cmd_decoder_slave (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irr_in(irr_in), .isr_in(isr_in), .rd_data(s_rd_data), .mask_q(s_mask_q),
    .edge_mode(s_edge_mode), .single_mode(s_single_mode), .vec_base(s_vec_base),
    .cascade_map(s_cascade_map), .auto_eoi(s_auto_eoi), .rd_sel_irr(s_rd_sel_irr),
    .eoi_valid(s_eoi_valid), .eoi_line(s_eoi_line));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one write; return at the falling edge after the capturing edge.
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #0.5;
  endtask

  task automatic sel(input logic a);
    addr = a;
    #0.5;
  endtask

  // Highest set bit, searched from the top down.
  function automatic int hi_line(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic exp_sel;
    logic exp_auto;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R11 reset state
    chk("R11 mask", mask_q, 8'h00);
    chk("R11 edge", edge_mode, 1'b0);
    chk("R11 single", single_mode, 1'b0);
    chk("R11 vec", vec_base, 8'h00);
    chk("R11 casc", cascade_map, 8'h00);
    chk("R11 auto", auto_eoi, 1'b0);
    chk("R11 rdsel", rd_sel_irr, 1'b1);
    chk("R11 eoi", eoi_valid, 1'b0);
    sel(1'b0);
    chk("R11 read irr", rd_data, 8'hC3);

    // R6 every mask value while idle
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      chk("R6 mask", mask_q, 32'(v));
      chk("R6 read mask", rd_data, 32'(v));
    end

    // R1..R5 all opening-byte low nibbles, both mode-byte auto values
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] vb, cb;
        vb = {4'(c), 4'h7} ^ {1'(k), 7'h00};
        cb = 8'hA5 ^ {4'(c), 4'(c)};
        wr(1'b0, 8'h11); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        chk("R5 auto set", auto_eoi, 1'b1);
        wr(1'b1, 8'h5A);
        wr(1'b0, {3'(k * 5), 1'b1, 4'(c)});
        chk("R1 mask clr", mask_q, 8'h00);
        chk("R1 edge", edge_mode, c[3]);
        chk("R1 single", single_mode, c[1]);
        exp_auto = c[0];
        chk("R2 auto", auto_eoi, exp_auto);
        wr(1'b1, vb);
        chk("R3 vec", vec_base, vb & 8'hF8);
        chk("R6 mask held", mask_q, 8'h00);
        if (c[1]) begin
          chk("R3 casc clr", cascade_map, 8'h00);
        end else begin
          wr(1'b1, cb);
          chk("R4 master casc", cascade_map, cb);
          chk("R4 slave id", s_cascade_map, cb & 8'h07);
          if (c[0]) begin
            wr(1'b1, {6'h2A, 1'(k), 1'b1});
            exp_auto = k[0];
            chk("R5 auto", auto_eoi, exp_auto);
          end
        end
        wr(1'b1, 8'h3C);
        chk("R3 R4 R5 setup ended", mask_q, 8'h3C);
        chk("R2 auto kept", auto_eoi, exp_auto);
      end
    end

    // R3 every vector byte, single mode without mode byte
    for (int v = 0; v < 256; v++) begin
      wr(1'b0, 8'h12);
      wr(1'b1, 8'(v));
      chk("R3 vec sweep", vec_base, 32'(v & 8'hF8));
    end

    // R7 R9 every command code against every line field
    wr(1'b1, 8'h77);
    isr_in = 8'h29;
    for (int cd = 0; cd < 8; cd++) begin
      for (int ln = 0; ln < 8; ln++) begin
        wr(1'b0, {3'(cd), 2'b00, 3'(ln)});
        if (cd == 3) begin
          chk("R7 strobe", eoi_valid, 1'b1);
          chk("R7 line", eoi_line, 32'(ln));
        end else if (cd == 1) begin
          chk("R8 strobe", eoi_valid, 1'b1);
          chk("R8 line", eoi_line, 32'd5);
        end else begin
          chk("R9 no strobe", eoi_valid, 1'b0);
        end
        chk("R9 mask kept", mask_q, 8'h77);
        chk("R9 rdsel kept", rd_sel_irr, 1'b1);
        @(negedge clk); #0.5;
        chk("R7 one cycle", eoi_valid, 1'b0);
      end
    end

    // R8 every in-service pattern
    for (int p = 0; p < 256; p++) begin
      isr_in = 8'(p);
      wr(1'b0, 8'h27);
      if (p == 0) begin
        chk("R8 empty", eoi_valid, 1'b0);
      end else begin
        chk("R8 strobe", eoi_valid, 1'b1);
        chk("R8 top", eoi_line, 32'(hi_line(8'(p))));
      end
    end

    // R10 read selection, all upper-bit and low-bit combinations
    isr_in = 8'h18;
    exp_sel = 1'b1;
    for (int hi = 0; hi < 8; hi++) begin
      for (int lo = 0; lo < 4; lo++) begin
        wr(1'b0, {3'(hi), 2'b01, 1'b0, 2'(lo)});
        if (lo[1]) exp_sel = lo[0];
        chk("R10 sel", rd_sel_irr, exp_sel);
        chk("R10 no strobe", eoi_valid, 1'b0);
        sel(1'b0);
        chk("R10 read", rd_data, exp_sel ? 8'hC3 : 8'h18);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule